// File: doc/BRIEF.md
# Status Register Write Guard

This block keeps the protection and write-enable state of a serial EEPROM's status register. It also decides, cycle by cycle, whether an array write or a status-register write may go ahead. A command decoder upstream gives it single-cycle strobes for four events: arm writes, disarm writes, load status and programming finished. With those strobes come the proposed status byte and the array address of a pending write. The block also sees the board-level write-protect pin, which is active low, and the busy flag from the programming timer.

The status byte it returns is laid out as follows:

- Bit 7 is the lock-enable bit, which pairs with the pin.
- Bits 3:2 choose the protected region.
- Bit 1 is the write-enable latch.
- Bit 0 mirrors the timer's busy flag.
- Bits 6:4 always read zero.

Region code 00 protects nothing. Code 01 protects the upper quarter of the address space, meaning the two top address bits are both 1. Code 10 protects the upper half, meaning the top address bit is 1. Code 11 protects every address.

Top module: `wp_status_guard`

## Requirements
- R1: After reset the status byte reads 0x00 while busy is low, and both allow outputs are 0.
- R2: An arm strobe sets status bit 1 from the next cycle. A disarm strobe clears it. When both strobes arrive in the same cycle, the bit ends up cleared.
- R3: A programming-finished strobe clears status bit 1 on the next cycle, even while busy is high.
- R4: While busy is high, status bit 0 reads 1, and arm, disarm and load strobes leave the stored state unchanged.
- R5: An accepted status load changes only bits 7, 3 and 2. Loading 0xFF with the latch set gives 0x8E. Bits 6:4 read 0.
- R6: The array-write allow output is 1 only when the latch is set, busy is low, and the address lies outside the region chosen by bits 3:2 (00 none, 01 top two address bits 11, 10 top bit 1, 11 all).
- R7: When bit 7 is 1 and the pin is low, the status-write allow output is 0 and a load strobe changes nothing.
- R8: When bit 7 is 0, the pin level has no effect on status-write permission.
- R9: With the latch clear, both allow outputs are 0 and a load strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdArm | input | 1 | Strobe that sets the write-enable latch |
| cmdDisarm | input | 1 | Strobe that clears the write-enable latch |
| cmdLoadStat | input | 1 | Strobe that requests a status-register write |
| cmdProgDone | input | 1 | Strobe that marks the end of a programming cycle |
| statIn | input | 8 | Proposed status byte |
| arrAddr | input | ADDR_W | Target address of the pending array write |
| wpPinN | input | 1 | Write-protect pin, active low |
| busyIn | input | 1 | Programming timer busy flag |
| statusOut | output | 8 | Readable status byte |
| arrWrAllow | output | 1 | Array write permitted |
| statWrAllow | output | 1 | Status write permitted |

## Verification
Several rules are checked by assertions on every cycle:

- No allow output rises while the latch is clear.
- The stored state holds steady while busy is high.
- The latch drops after a programming-finished strobe.
- The pin lock blocks status writes.
- Code 11 refuses every array address.

Only the bench scenarios can show the exact region boundaries for each code, and that the latch and busy bits cannot be written. They also show that clearing wins when arm and disarm arrive together, and that the pin is ignored once the lock-enable bit is clear.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic loadStat;
  } ctlStrobes_t;

  typedef enum logic [1:0] {
    PROT_NONE    = 2'b00,
    PROT_QUARTER = 2'b01,
    PROT_HALF    = 2'b10,
    PROT_ALL     = 2'b11
  } protSel_t;
endpackage

// File: rtl/wpg_ctrl.sv
module wpg_ctrl
  import wpg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdArm,
  input  logic        cmdDisarm,
  input  logic        cmdLoadStat,
  input  logic        cmdProgDone,
  input  logic        busyIn,
  input  logic        wpPinN,
  input  logic        wel,
  input  logic        wpen,
  output ctlStrobes_t ctl,
  output logic        statWrAllow
);
  logic idle;
  logic statUnlocked;

  assign idle         = !busyIn;
  assign statUnlocked = !(wpen && !wpPinN);
  assign statWrAllow  = wel && idle && statUnlocked;

  always_comb begin
    ctl.clrWel   = cmdProgDone || (idle && cmdDisarm);
    ctl.setWel   = idle && cmdArm && !cmdDisarm;
    ctl.loadStat = cmdLoadStat && statWrAllow;
  end

  // R7: the pin lock overrides the latch
  a_r7_pin_lock: assert property (@(posedge clk) disable iff (!rstN)
    (wpen && !wpPinN) |-> !statWrAllow);

  // R9: no status write is granted without the latch
  a_r9_stat_needs_wel: assert property (@(posedge clk) disable iff (!rstN)
    !wel |-> !statWrAllow);
endmodule

// File: rtl/wpg_datapath.sv
module wpg_datapath
  import wpg_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic              newWpen,
  input  logic [1:0]        newBp,
  input  logic [ADDR_W-1:0] arrAddr,
  input  logic              busyIn,
  output logic              wel,
  output logic              wpen,
  output logic [1:0]        bp,
  output logic [7:0]        statusOut,
  output logic              arrWrAllow
);
  localparam int TOP = ADDR_W - 1;

  logic addrProt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wel  <= 1'b0;
      wpen <= 1'b0;
      bp   <= 2'b00;
    end else begin
      if (ctl.clrWel)      wel <= 1'b0;
      else if (ctl.setWel) wel <= 1'b1;
      if (ctl.loadStat) begin
        wpen <= newWpen;
        bp   <= newBp;
      end
    end
  end

  generate
    if (ADDR_W >= 2) begin : g_wide
      always_comb begin
        case (protSel_t'(bp))
          PROT_QUARTER: addrProt = arrAddr[TOP] && arrAddr[TOP-1];
          PROT_HALF:    addrProt = arrAddr[TOP];
          PROT_ALL:     addrProt = 1'b1;
          default:      addrProt = 1'b0;
        endcase
      end
    end else begin : g_narrow
      always_comb begin
        case (protSel_t'(bp))
          PROT_NONE: addrProt = 1'b0;
          PROT_ALL:  addrProt = 1'b1;
          default:   addrProt = arrAddr[TOP];
        endcase
      end
    end
  endgenerate

  assign arrWrAllow = wel && !busyIn && !addrProt;
  assign statusOut  = {wpen, 3'b000, bp, wel, busyIn};

  // R3: programming-finished always drops the latch
  a_r3_done_clears: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clrWel |=> !wel);

  // R6: the whole-array code refuses every address
  a_r6_all_locked: assert property (@(posedge clk) disable iff (!rstN)
    (bp == 2'b11) |-> !arrWrAllow);

  // R9: no array write without the latch
  a_r9_arr_needs_wel: assert property (@(posedge clk) disable iff (!rstN)
    !wel |-> !arrWrAllow);
endmodule

// File: rtl/wp_status_guard.sv
module wp_status_guard
  import wpg_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdArm,
  input  logic              cmdDisarm,
  input  logic              cmdLoadStat,
  input  logic              cmdProgDone,
  input  logic [7:0]        statIn,
  input  logic [ADDR_W-1:0] arrAddr,
  input  logic              wpPinN,
  input  logic              busyIn,
  output logic [7:0]        statusOut,
  output logic              arrWrAllow,
  output logic              statWrAllow
);
  ctlStrobes_t ctl;
  logic        wel;
  logic        wpen;
  logic [1:0]  bp;

  wpg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .cmdArm(cmdArm), .cmdDisarm(cmdDisarm),
    .cmdLoadStat(cmdLoadStat), .cmdProgDone(cmdProgDone),
    .busyIn(busyIn), .wpPinN(wpPinN),
    .wel(wel), .wpen(wpen),
    .ctl(ctl), .statWrAllow(statWrAllow)
  );

  wpg_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .newWpen(statIn[7]), .newBp(statIn[3:2]),
    .arrAddr(arrAddr), .busyIn(busyIn),
    .wel(wel), .wpen(wpen), .bp(bp),
    .statusOut(statusOut), .arrWrAllow(arrWrAllow)
  );

  // R4: busy freezes the stored state, except the finished strobe
  a_r4_busy_freeze: assert property (@(posedge clk) disable iff (!rstN)
    (busyIn && !cmdProgDone) |=> $stable({wpen, bp, wel}));
endmodule

// File: tb/wp_status_guard_test.sv
module wp_status_guard_test;
  localparam int ADDR_W = 14;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdArm = 1'b0, cmdDisarm = 1'b0, cmdLoadStat = 1'b0, cmdProgDone = 1'b0;
  logic [7:0] statIn = 8'h00;
  logic [ADDR_W-1:0] arrAddr = '0;
  logic wpPinN = 1'b1;
  logic busyIn = 1'b0;
  logic [7:0] statusOut;
  logic arrWrAllow, statWrAllow;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  wp_status_guard #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rstN(rstN),
    .cmdArm(cmdArm), .cmdDisarm(cmdDisarm),
    .cmdLoadStat(cmdLoadStat), .cmdProgDone(cmdProgDone),
    .statIn(statIn), .arrAddr(arrAddr), .wpPinN(wpPinN), .busyIn(busyIn),
    .statusOut(statusOut), .arrWrAllow(arrWrAllow), .statWrAllow(statWrAllow)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Strobe is held for one clock edge; the result is visible at the following negedge.
  task automatic pulse(bit arm, bit dis, bit ld, bit done);
    cmdArm = arm; cmdDisarm = dis; cmdLoadStat = ld; cmdProgDone = done;
    @(negedge clk);
    cmdArm = 0; cmdDisarm = 0; cmdLoadStat = 0; cmdProgDone = 0;
  endtask

  task automatic setStatus(logic [7:0] v);
    pulse(1, 0, 0, 0);
    statIn = v;
    pulse(0, 0, 1, 0);
    pulse(0, 0, 0, 1);
  endtask

  task automatic t_reset;
    check("R1 status", statusOut, 8'h00);
    check("R1 arr", {7'b0, arrWrAllow}, 8'h00);
    check("R1 stat", {7'b0, statWrAllow}, 8'h00);
  endtask

  task automatic t_latch;
    pulse(1, 0, 0, 0);
    check("R2 arm", statusOut, 8'h02);
    pulse(0, 1, 0, 0);
    check("R2 disarm", statusOut, 8'h00);
    pulse(1, 1, 0, 0);
    check("R2 both", statusOut, 8'h00);
  endtask

  task automatic t_no_wel;
    statIn = 8'hFF;
    check("R9 arr", {7'b0, arrWrAllow}, 8'h00);
    check("R9 stat", {7'b0, statWrAllow}, 8'h00);
    pulse(0, 0, 1, 0);
    check("R9 load ignored", statusOut, 8'h00);
  endtask

  task automatic t_load;
    pulse(1, 0, 0, 0);
    statIn = 8'hFF;
    pulse(0, 0, 1, 0);
    check("R5 load ff", statusOut, 8'h8E);
    pulse(0, 0, 0, 1);
    check("R3 done clears", statusOut, 8'h8C);
    setStatus(8'h00);
    check("R5 cleared", statusOut, 8'h00);
  endtask

  task automatic t_regions;
    logic [ADDR_W-1:0] addrs [5] = '{14'h0000, 14'h1FFF, 14'h2000, 14'h2FFF, 14'h3FFF};
    for (int code = 0; code < 4; code++) begin
      setStatus(8'(code << 2));
      pulse(1, 0, 0, 0);
      for (int i = 0; i < 5; i++) begin
        bit prot;
        arrAddr = addrs[i];
        prot = (code == 3) || (code == 2 && addrs[i][13]) ||
               (code == 1 && addrs[i][13] && addrs[i][12]);
        @(negedge clk);
        check($sformatf("R6 code%0d addr%h", code, addrs[i]), {7'b0, arrWrAllow}, {7'b0, !prot});
      end
      pulse(0, 0, 0, 1);
    end
    setStatus(8'h00);
  endtask

  task automatic t_busy;
    pulse(1, 0, 0, 0);
    busyIn = 1'b1;
    @(negedge clk);
    check("R4 busy bit", statusOut, 8'h03);
    check("R4 arr blocked", {7'b0, arrWrAllow}, 8'h00);
    pulse(0, 1, 0, 0);
    check("R4 disarm ignored", statusOut, 8'h03);
    statIn = 8'h8C;
    pulse(0, 0, 1, 0);
    check("R4 load ignored", statusOut, 8'h03);
    pulse(0, 0, 0, 1);
    check("R3 done while busy", statusOut, 8'h01);
    busyIn = 1'b0;
    @(negedge clk);
    check("R4 idle", statusOut, 8'h00);
  endtask

  task automatic t_lock;
    setStatus(8'h80);
    wpPinN = 1'b0;
    pulse(1, 0, 0, 0);
    check("R7 allow low", {7'b0, statWrAllow}, 8'h00);
    statIn = 8'h0C;
    pulse(0, 0, 1, 0);
    check("R7 load blocked", statusOut, 8'h82);
    wpPinN = 1'b1;
    @(negedge clk);
    check("R7 pin high allows", {7'b0, statWrAllow}, 8'h01);
    statIn = 8'h00;
    pulse(0, 0, 1, 0);
    pulse(0, 0, 0, 1);
    check("R8 unlocked", statusOut, 8'h00);
    wpPinN = 1'b0;
    pulse(1, 0, 0, 0);
    check("R8 pin ignored", {7'b0, statWrAllow}, 8'h01);
    statIn = 8'h04;
    pulse(0, 0, 1, 0);
    check("R8 load taken", statusOut, 8'h06);
    wpPinN = 1'b1;
    pulse(0, 0, 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_latch();
    t_no_wel();
    t_load();
    t_regions();
    t_busy();
    t_lock();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule